// File: doc/BRIEF.md
# Superscalar In-Order Dispatch Allocator

This block sits between the instruction window and the execution back end of a four-wide out-of-order core. Each cycle it looks at the oldest four entries of the instruction window. Every entry names its target execution unit, the register class it writes and the number of source operands it reads. The block lets through the longest in-order prefix of these entries that can be given resources. For every instruction it lets through, in the same cycle, it takes one slot in the target unit's reservation station, one slot in the shared completion buffer and, when the instruction writes a register, one rename slot of the written class.

When an instruction cannot go, no younger instruction goes in that cycle. The block then reports a 3-bit stall code that names why the oldest blocked instruction waited. Slots come back through release inputs once the reservation station issues, the completion logic retires, or a rename value is committed. A returned slot can be given out again from the following cycle. A release that would return more slots than are held is reported on an error output and clamped, so no counter ever goes above its capacity.

There are six execution units: two single-cycle integer units, one multi-cycle integer unit, a floating-point unit, a load/store unit and a branch unit. Their reservation stations hold 2, 2, 2, 2, 3 and 4 entries. The completion buffer holds 16 entries. The rename pools hold 8 general, 8 floating-point and 16 condition-field slots.

Top module: `dsp_alloc`

## Requirements
- R1: While reset is high, and afterwards until the first dispatch, every free counter equals its capacity and `rel_err` is 0. The capacities are: reservation stations, unit codes 0 to 5 = 2,2,2,2,3,4; completion buffer = 16; rename pools general/float/condition = 8/8/16.
- R2: `disp_mask` marks, from slot 0 up, a contiguous run of valid slots. At most 4 slots go per cycle. A cleared `slot_valid` bit ends the window. `stall_code` is 0 exactly when every valid slot of the window went. `disp_cnt` is the number of bits set in `disp_mask`.
- R3: Each dispatched instruction lowers, at the next clock edge, its unit's reservation-station counter by 1 and the completion counter by 1. When its class code (0 none, 1 general, 2 float, 3 condition) is not 0, it also lowers that rename counter by 1.
- R4: An instruction whose unit has no free reservation-station slot stalls with code 1. Unit codes 6 and 7 have no slots and always stall with code 1.
- R5: An instruction whose unit already received an older instruction in the same cycle stalls with code 2.
- R6: An instruction that finds no completion slot left after the older dispatches of the cycle stalls with code 3.
- R7: An instruction with a non-zero class code that finds no slot left in that rename pool after the older dispatches of the cycle stalls with code 4.
- R8: The source-operand counts of the dispatched instructions, added together, never exceed `rd_ports`. An instruction that would exceed them stalls with code 5.
- R9: A serializing instruction dispatches only from slot 0 and only when all 16 completion slots are free. Otherwise it stalls with code 6. After a serializing instruction dispatches, the next valid slot of the same cycle stalls with code 6.
- R10: A branch-unit instruction (unit 5) with `slot_spr` set stalls with code 7 while `spr_pending` is 1. The `slot_spr` flag has no effect on other units.
- R11: When several causes apply to one instruction, the code reported follows this priority: 6, 7, 2, 1, 3, 4, 5.
- R12: Slots released in a cycle add to the free counters at the clock edge. They cannot be used by dispatch in the cycle of the release.
- R13: A release larger than the number of held slots of that pool sets `rel_err` in that cycle. The counter then saturates at its capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | 4 | Window slot holds an instruction (slot 0 oldest) |
| slot_unit | input | 12 | 3-bit unit code per slot |
| slot_cls | input | 8 | 2-bit written register class per slot |
| slot_nsrc | input | 8 | 2-bit source operand count per slot |
| slot_ser | input | 4 | Slot is serializing |
| slot_spr | input | 4 | Branch reads a special register |
| spr_pending | input | 1 | A special-register move is in flight |
| rd_ports | input | 4 | Register read ports available this cycle |
| rs_rel | input | 6 | One reservation-station slot returned per unit |
| cb_rel | input | 3 | Completion slots returned |
| ren_rel | input | 9 | 3-bit rename slots returned per class (general, float, condition) |
| disp_mask | output | 4 | Slots dispatched this cycle |
| disp_cnt | output | 3 | Number of dispatched slots |
| stall_code | output | 3 | Cause for the oldest blocked slot, 0 if none |
| rs_free | output | 18 | 3-bit free count per unit |
| cb_free | output | 5 | Free completion slots |
| ren_free | output | 15 | 5-bit free count per class (general, float, condition) |
| rel_err | output | 1 | A release exceeded the held slots |

## Verification
The assertions assume that the valid bits of the window form a contiguous run from slot 0, and that unit codes stay below 6 whenever the prefix check on `stall_code` matters. The stimulus only produces contiguous windows with unit codes 0 to 5. Release amounts are random and sometimes exceed what is held, so the saturation and error path is exercised. Alternating phases of scarce and plentiful releases drive each pool to empty and back to full, and every stall code comes up.

// File: rtl/dsp_alloc_pkg.sv
package dsp_alloc_pkg;

    localparam int NUNIT  = 6;
    localparam int UNIT_W = 3;
    localparam int NCLS   = 4;
    localparam int CLS_W  = 2;

    typedef enum logic [UNIT_W-1:0] {
        U_ALU0 = 3'd0, U_ALU1 = 3'd1, U_MUL = 3'd2,
        U_FPU  = 3'd3, U_LSU  = 3'd4, U_BRU = 3'd5
    } unit_e;

    typedef enum logic [CLS_W-1:0] {
        C_NONE = 2'd0, C_GPR = 2'd1, C_FPR = 2'd2, C_CRF = 2'd3
    } cls_e;

    typedef enum logic [2:0] {
        ST_NONE     = 3'd0,
        ST_RS_FULL  = 3'd1,
        ST_SAME_U   = 3'd2,
        ST_CB_FULL  = 3'd3,
        ST_REN_FULL = 3'd4,
        ST_PORTS    = 3'd5,
        ST_SERIAL   = 3'd6,
        ST_SPR_WAIT = 3'd7
    } stall_e;

    typedef struct packed {
        logic             valid;
        logic [UNIT_W-1:0] unit;
        cls_e             cls;
        logic [1:0]       nsrc;
        logic             ser;
        logic             spr;
    } slot_t;

    function automatic int rs_cap(input int u);
        case (u)
            4:       return 3;
            5:       return 4;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/dsp_credit_pool.sv
module dsp_credit_pool #(
    parameter int CAP    = 8,
    parameter int CNT_W  = 4,
    parameter int TAKE_W = 3,
    parameter int REL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAKE_W-1:0] take,
    input  logic [REL_W-1:0]  rel,
    output logic [CNT_W-1:0]  free,
    output logic              err
);
    localparam int M1 = (CNT_W > REL_W) ? CNT_W : REL_W;
    localparam int M2 = (M1 > TAKE_W) ? M1 : TAKE_W;
    localparam int XW = M2 + 1;

    logic [XW-1:0] held;
    logic [XW-1:0] rel_x;
    logic [XW-1:0] rel_ok;
    logic [XW-1:0] nxt;

    always_comb begin
        held   = XW'(CAP) - XW'(free);
        rel_x  = XW'(rel);
        err    = rel_x > held;
        rel_ok = err ? held : rel_x;
        nxt    = XW'(free) - XW'(take) + rel_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) free <= CNT_W'(CAP);
        else     free <= CNT_W'(nxt);
    end

endmodule

// File: rtl/dsp_slot_select.sv
module dsp_slot_select
    import dsp_alloc_pkg::*;
#(
    parameter int NSLOT    = 4,
    parameter int CB_DEPTH = 16,
    parameter int RS_W     = 3,
    parameter int CB_W     = 5,
    parameter int REN_W    = 5,
    parameter int PORT_W   = 4,
    parameter int SEL_W    = 3
) (
    input  slot_t [NSLOT-1:0]                  slots,
    input  logic  [2**UNIT_W-1:0][RS_W-1:0]    rs_free,
    input  logic  [CB_W-1:0]                   cb_free,
    input  logic  [NCLS-1:0][REN_W-1:0]        ren_free,
    input  logic  [PORT_W-1:0]                 rd_ports,
    input  logic                               spr_pending,
    output logic  [NSLOT-1:0]                  disp_mask,
    output stall_e                             code,
    output logic  [2**UNIT_W-1:0]              unit_used,
    output logic  [SEL_W-1:0]                  cb_used,
    output logic  [NCLS-1:0][SEL_W-1:0]        ren_used
);
    localparam int PU_W = PORT_W + 1;

    logic          stop;
    logic          ser_seen;
    logic [PU_W-1:0] ports_used;
    stall_e        why;

    always_comb begin
        disp_mask  = '0;
        code       = ST_NONE;
        unit_used  = '0;
        cb_used    = '0;
        ren_used   = '0;
        ports_used = '0;
        stop       = 1'b0;
        ser_seen   = 1'b0;
        why        = ST_NONE;
        for (int i = 0; i < NSLOT; i++) begin
            if (!stop) begin
                if (!slots[i].valid) begin
                    stop = 1'b1;
                end else begin
                    why = ST_NONE;
                    if (ser_seen || (slots[i].ser &&
                        (i != 0 || cb_free != CB_W'(CB_DEPTH))))
                        why = ST_SERIAL;
                    else if (slots[i].spr && slots[i].unit == U_BRU && spr_pending)
                        why = ST_SPR_WAIT;
                    else if (unit_used[slots[i].unit])
                        why = ST_SAME_U;
                    else if (rs_free[slots[i].unit] == '0)
                        why = ST_RS_FULL;
                    else if (cb_free <= CB_W'(cb_used))
                        why = ST_CB_FULL;
                    else if (slots[i].cls != C_NONE &&
                             ren_free[slots[i].cls] <= REN_W'(ren_used[slots[i].cls]))
                        why = ST_REN_FULL;
                    else if (ports_used + PU_W'(slots[i].nsrc) > PU_W'(rd_ports))
                        why = ST_PORTS;

                    if (why != ST_NONE) begin
                        stop = 1'b1;
                        code = why;
                    end else begin
                        disp_mask[i]             = 1'b1;
                        unit_used[slots[i].unit] = 1'b1;
                        cb_used                  = cb_used + 1'b1;
                        if (slots[i].cls != C_NONE)
                            ren_used[slots[i].cls] = ren_used[slots[i].cls] + 1'b1;
                        ports_used = ports_used + PU_W'(slots[i].nsrc);
                        if (slots[i].ser) ser_seen = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dsp_alloc.sv
module dsp_alloc
    import dsp_alloc_pkg::*;
#(
    parameter int NSLOT    = 4,
    parameter int CB_DEPTH = 16,
    parameter int GPR_REN  = 8,
    parameter int FPR_REN  = 8,
    parameter int CRF_REN  = 16,
    parameter int PORT_W   = 4,
    parameter int REL_W    = 3,
    localparam int SEL_W   = $clog2(NSLOT + 1),
    localparam int RS_W    = 3,
    localparam int CB_W    = $clog2(CB_DEPTH + 1),
    localparam int REN_M1  = (GPR_REN > FPR_REN) ? GPR_REN : FPR_REN,
    localparam int REN_MAX = (REN_M1 > CRF_REN) ? REN_M1 : CRF_REN,
    localparam int REN_W   = $clog2(REN_MAX + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NSLOT-1:0]          slot_valid,
    input  logic [NSLOT*UNIT_W-1:0]   slot_unit,
    input  logic [NSLOT*CLS_W-1:0]    slot_cls,
    input  logic [NSLOT*2-1:0]        slot_nsrc,
    input  logic [NSLOT-1:0]          slot_ser,
    input  logic [NSLOT-1:0]          slot_spr,
    input  logic                      spr_pending,
    input  logic [PORT_W-1:0]         rd_ports,
    input  logic [NUNIT-1:0]          rs_rel,
    input  logic [REL_W-1:0]          cb_rel,
    input  logic [3*REL_W-1:0]        ren_rel,
    output logic [NSLOT-1:0]          disp_mask,
    output logic [SEL_W-1:0]          disp_cnt,
    output logic [2:0]                stall_code,
    output logic [NUNIT*RS_W-1:0]     rs_free,
    output logic [CB_W-1:0]           cb_free,
    output logic [3*REN_W-1:0]        ren_free,
    output logic                      rel_err
);

    slot_t [NSLOT-1:0]               slots;
    logic  [2**UNIT_W-1:0][RS_W-1:0] rs_free_a;
    logic  [NCLS-1:0][REN_W-1:0]     ren_free_a;
    logic  [2**UNIT_W-1:0]           unit_used;
    logic  [SEL_W-1:0]               cb_used;
    logic  [NCLS-1:0][SEL_W-1:0]     ren_used;
    logic  [NUNIT-1:0]               rs_err;
    logic  [2:0]                     ren_err;
    logic                            cb_err;
    stall_e                          code;

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            slots[i].valid = slot_valid[i];
            slots[i].unit  = slot_unit[i*UNIT_W +: UNIT_W];
            slots[i].cls   = cls_e'(slot_cls[i*CLS_W +: CLS_W]);
            slots[i].nsrc  = slot_nsrc[i*2 +: 2];
            slots[i].ser   = slot_ser[i];
            slots[i].spr   = slot_spr[i];
        end
    end

    dsp_slot_select #(
        .NSLOT(NSLOT), .CB_DEPTH(CB_DEPTH), .RS_W(RS_W), .CB_W(CB_W),
        .REN_W(REN_W), .PORT_W(PORT_W), .SEL_W(SEL_W)
    ) u_sel (
        .slots(slots), .rs_free(rs_free_a), .cb_free(cb_free),
        .ren_free(ren_free_a), .rd_ports(rd_ports), .spr_pending(spr_pending),
        .disp_mask(disp_mask), .code(code), .unit_used(unit_used),
        .cb_used(cb_used), .ren_used(ren_used)
    );

    genvar u;
    generate
        for (u = 0; u < 2**UNIT_W; u++) begin : g_rs
            if (u < NUNIT) begin : g_pool
                dsp_credit_pool #(
                    .CAP(rs_cap(u)), .CNT_W(RS_W), .TAKE_W(1), .REL_W(1)
                ) u_pool (
                    .clk(clk), .rst(rst), .take(unit_used[u]), .rel(rs_rel[u]),
                    .free(rs_free_a[u]), .err(rs_err[u])
                );
                assign rs_free[u*RS_W +: RS_W] = rs_free_a[u];
            end else begin : g_none
                assign rs_free_a[u] = '0;
            end
        end
    endgenerate

    dsp_credit_pool #(
        .CAP(CB_DEPTH), .CNT_W(CB_W), .TAKE_W(SEL_W), .REL_W(REL_W)
    ) u_cb (
        .clk(clk), .rst(rst), .take(cb_used), .rel(cb_rel),
        .free(cb_free), .err(cb_err)
    );

    genvar c;
    generate
        for (c = 1; c < NCLS; c++) begin : g_ren
            localparam int CAP_C = (c == 1) ? GPR_REN : (c == 2) ? FPR_REN : CRF_REN;
            dsp_credit_pool #(
                .CAP(CAP_C), .CNT_W(REN_W), .TAKE_W(SEL_W), .REL_W(REL_W)
            ) u_pool (
                .clk(clk), .rst(rst), .take(ren_used[c]),
                .rel(ren_rel[(c-1)*REL_W +: REL_W]),
                .free(ren_free_a[c]), .err(ren_err[c-1])
            );
            assign ren_free[(c-1)*REN_W +: REN_W] = ren_free_a[c];
        end
    endgenerate
    assign ren_free_a[0] = '0;

    assign disp_cnt   = cb_used;
    assign stall_code = code;
    assign rel_err    = (|rs_err) | cb_err | (|ren_err);

endmodule

// File: rtl/dsp_alloc_chk.sv
module dsp_alloc_chk #(
    parameter int NSLOT    = 4,
    parameter int CB_DEPTH = 16,
    parameter int REL_W    = 3,
    parameter int SEL_W    = 3,
    parameter int CB_W     = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NSLOT-1:0]     slot_valid,
    input logic [NSLOT*3-1:0]   slot_unit,
    input logic [NSLOT-1:0]     slot_ser,
    input logic [NSLOT-1:0]     slot_spr,
    input logic                 spr_pending,
    input logic [5:0]           rs_rel,
    input logic [REL_W-1:0]     cb_rel,
    input logic [3*REL_W-1:0]   ren_rel,
    input logic [NSLOT-1:0]     disp_mask,
    input logic [SEL_W-1:0]     disp_cnt,
    input logic [2:0]           stall_code,
    input logic [CB_W-1:0]      cb_free,
    input logic                 rel_err
);
    AST_DISP_PREFIX: assert property (@(posedge clk) disable iff (rst)
        ((disp_mask & (disp_mask + NSLOT'(1))) == '0)); // R2
    AST_DISP_VALID: assert property (@(posedge clk) disable iff (rst)
        ((disp_mask & ~slot_valid) == '0)); // R2
    AST_NO_STALL_ALL_GO: assert property (@(posedge clk) disable iff (rst)
        (stall_code == 3'd0) |-> ((slot_valid & ~disp_mask) == '0)); // R2
    AST_CB_TRACK: assert property (@(posedge clk) disable iff (rst)
        (cb_rel == '0) |=> (cb_free == $past(cb_free) - CB_W'($past(disp_cnt)))); // R3
    AST_CB_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cb_free <= CB_W'(CB_DEPTH))); // R13
    AST_QUIET_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (rs_rel == '0 && cb_rel == '0 && ren_rel == '0) |-> !rel_err); // R13
    AST_SPR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (slot_valid[0] && slot_spr[0] && slot_unit[2:0] == 3'd5 && spr_pending)
            |-> !disp_mask[0]); // R10
    AST_SER_ALONE: assert property (@(posedge clk) disable iff (rst)
        (disp_mask[0] && slot_ser[0]) |-> !disp_mask[1]); // R9
    AST_SAME_UNIT: assert property (@(posedge clk) disable iff (rst)
        (disp_mask[0] && disp_mask[1]) |-> (slot_unit[2:0] != slot_unit[5:3])); // R5
endmodule

bind dsp_alloc dsp_alloc_chk #(
    .NSLOT(NSLOT), .CB_DEPTH(CB_DEPTH), .REL_W(REL_W), .SEL_W(SEL_W), .CB_W(CB_W)
) u_chk (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_unit(slot_unit),
    .slot_ser(slot_ser), .slot_spr(slot_spr), .spr_pending(spr_pending),
    .rs_rel(rs_rel), .cb_rel(cb_rel), .ren_rel(ren_rel), .disp_mask(disp_mask),
    .disp_cnt(disp_cnt), .stall_code(stall_code), .cb_free(cb_free), .rel_err(rel_err)
);

// File: tb/dsp_alloc_tb.sv
module dsp_alloc_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  slot_valid = '0;
    logic [11:0] slot_unit = '0;
    logic [7:0]  slot_cls = '0;
    logic [7:0]  slot_nsrc = '0;
    logic [3:0]  slot_ser = '0;
    logic [3:0]  slot_spr = '0;
    logic        spr_pending = 1'b0;
    logic [3:0]  rd_ports = '0;
    logic [5:0]  rs_rel = '0;
    logic [2:0]  cb_rel = '0;
    logic [8:0]  ren_rel = '0;
    logic [3:0]  disp_mask;
    logic [2:0]  disp_cnt;
    logic [2:0]  stall_code;
    logic [17:0] rs_free;
    logic [4:0]  cb_free;
    logic [14:0] ren_free;
    logic        rel_err;

    dsp_alloc u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // stimulus
    int s_v, s_u[4], s_c[4], s_n[4], s_s[4], s_p[4];
    int s_pend, s_ports, s_rsr[6], s_cbr, s_renr[4];
    // reference state
    int m_rs[6], m_cb, m_ren[4];
    int cap_rs[6] = '{2, 2, 2, 2, 3, 4};
    int cap_ren[4] = '{0, 8, 8, 16};
    // expected
    int e_mask, e_code, e_err, e_cnt, e_takeu[8], e_takec[4];

    function automatic string tag_of(int code);
        case (code)
            0: return "R2";  1: return "R4";  2: return "R5";  3: return "R6";
            4: return "R7";  5: return "R8";  6: return "R9";  default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic clear_stim();
        s_v = 0; s_pend = 0; s_ports = 8; s_cbr = 0;
        for (int i = 0; i < 4; i++) begin
            s_u[i] = 0; s_c[i] = 0; s_n[i] = 0; s_s[i] = 0; s_p[i] = 0; s_renr[i] = 0;
        end
        for (int i = 0; i < 6; i++) s_rsr[i] = 0;
    endtask

    task automatic drive();
        slot_valid  = 4'((1 << s_v) - 1);
        for (int i = 0; i < 4; i++) begin
            slot_unit[i*3 +: 3] = 3'(s_u[i]);
            slot_cls[i*2 +: 2]  = 2'(s_c[i]);
            slot_nsrc[i*2 +: 2] = 2'(s_n[i]);
            slot_ser[i]         = 1'(s_s[i]);
            slot_spr[i]         = 1'(s_p[i]);
        end
        spr_pending = 1'(s_pend);
        rd_ports    = 4'(s_ports);
        for (int i = 0; i < 6; i++) rs_rel[i] = 1'(s_rsr[i]);
        cb_rel = 3'(s_cbr);
        for (int c = 1; c < 4; c++) ren_rel[(c-1)*3 +: 3] = 3'(s_renr[c]);
    endtask

    // Reference: in-order scan with fixed priority of causes.
    task automatic model();
        int ports, cbu, renu[4], used[8], serd, code;
        ports = 0; cbu = 0; serd = 0;
        for (int k = 0; k < 4; k++) renu[k] = 0;
        for (int k = 0; k < 8; k++) used[k] = 0;
        e_mask = 0; e_code = 0;
        for (int i = 0; i < s_v; i++) begin
            int f;
            f = (s_u[i] < 6) ? m_rs[s_u[i]] : 0;
            code = 0;
            if (serd == 1 || (s_s[i] == 1 && (i != 0 || m_cb != 16))) code = 6;
            else if (s_p[i] == 1 && s_u[i] == 5 && s_pend == 1) code = 7;
            else if (used[s_u[i]] == 1) code = 2;
            else if (f == 0) code = 1;
            else if (cbu >= m_cb) code = 3;
            else if (s_c[i] != 0 && renu[s_c[i]] >= m_ren[s_c[i]]) code = 4;
            else if (ports + s_n[i] > s_ports) code = 5;
            if (code != 0) begin
                e_code = code;
                break;
            end
            e_mask |= (1 << i);
            used[s_u[i]] = 1; cbu++; ports += s_n[i];
            if (s_c[i] != 0) renu[s_c[i]]++;
            if (s_s[i] == 1) serd = 1;
        end
        e_cnt = cbu;
        for (int k = 0; k < 8; k++) e_takeu[k] = used[k];
        for (int k = 0; k < 4; k++) e_takec[k] = renu[k];
        e_err = 0;
        for (int k = 0; k < 6; k++) if (s_rsr[k] > cap_rs[k] - m_rs[k]) e_err = 1;
        if (s_cbr > 16 - m_cb) e_err = 1;
        for (int k = 1; k < 4; k++) if (s_renr[k] > cap_ren[k] - m_ren[k]) e_err = 1;
    endtask

    task automatic update();
        int r;
        for (int k = 0; k < 6; k++) begin
            r = s_rsr[k]; if (r > cap_rs[k] - m_rs[k]) r = cap_rs[k] - m_rs[k];
            m_rs[k] = m_rs[k] - e_takeu[k] + r;
        end
        r = s_cbr; if (r > 16 - m_cb) r = 16 - m_cb;
        m_cb = m_cb - e_cnt + r;
        for (int k = 1; k < 4; k++) begin
            r = s_renr[k]; if (r > cap_ren[k] - m_ren[k]) r = cap_ren[k] - m_ren[k];
            m_ren[k] = m_ren[k] - e_takec[k] + r;
        end
    endtask

    task automatic compare_all();
        chk({"R2 R11 mask, code ", tag_of(e_code)}, int'(disp_mask), e_mask);
        chk({"R11 stall code ", tag_of(e_code)}, int'(stall_code), e_code);
        chk("R2 disp_cnt", int'(disp_cnt), e_cnt);
        chk("R13 rel_err", int'(rel_err), e_err);
        for (int k = 0; k < 6; k++)
            chk("R3 R12 rs_free", int'(rs_free[k*3 +: 3]), m_rs[k]);
        chk("R3 R12 cb_free", int'(cb_free), m_cb);
        for (int k = 1; k < 4; k++)
            chk("R3 R13 ren_free", int'(ren_free[(k-1)*5 +: 5]), m_ren[k]);
    endtask

    task automatic step();
        @(negedge clk);
        drive();
        #1;
        model();
        compare_all();
        update();
    endtask

    task automatic rand_stim(int scarce);
        clear_stim();
        s_v = $urandom_range(0, 4);
        for (int i = 0; i < 4; i++) begin
            s_u[i] = $urandom_range(0, 5);
            s_c[i] = $urandom_range(0, 3);
            s_n[i] = $urandom_range(0, 3);
            s_s[i] = ($urandom_range(0, 15) == 0) ? 1 : 0;
            s_p[i] = $urandom_range(0, 3) == 0 ? 1 : 0;
        end
        s_pend  = ($urandom_range(0, 2) == 0) ? 1 : 0;
        s_ports = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 8) : 8;
        for (int k = 0; k < 6; k++) s_rsr[k] = ($urandom_range(0, scarce ? 5 : 1) == 0) ? 1 : 0;
        s_cbr = scarce ? (($urandom_range(0, 3) == 0) ? 1 : 0) : $urandom_range(0, 4);
        for (int k = 1; k < 4; k++)
            s_renr[k] = scarce ? (($urandom_range(0, 3) == 0) ? 1 : 0) : $urandom_range(0, 4);
    endtask

    initial begin
        clear_stim();
        drive();
        for (int k = 0; k < 6; k++) m_rs[k] = cap_rs[k];
        m_cb = 16;
        for (int k = 0; k < 4; k++) m_ren[k] = cap_ren[k];
        repeat (3) @(posedge clk);
        #1;
        // R1: counters at capacity during reset
        chk("R1 cb_free in reset", int'(cb_free), 16);
        chk("R1 lsu rs_free in reset", int'(rs_free[12 +: 3]), 3);
        chk("R1 crf ren_free in reset", int'(ren_free[10 +: 5]), 16);
        chk("R1 rel_err in reset", int'(rel_err), 0);
        @(negedge clk);
        rst = 1'b0;
        step();  // R1: idle cycle after reset compares all counters at capacity

        // R5: two to the same unit
        clear_stim(); s_v = 2; s_u[0] = 0; s_u[1] = 0; step();
        // R4: fill the load/store station then stall
        clear_stim(); s_v = 1; s_u[0] = 4; step(); step(); step(); step();
        // R12: release in this cycle not usable now
        clear_stim(); s_v = 1; s_u[0] = 4; s_rsr[4] = 1; step();
        clear_stim(); s_v = 1; s_u[0] = 4; step();
        // R9: serializing not in slot 0
        clear_stim(); s_v = 2; s_u[0] = 1; s_u[1] = 2; s_s[1] = 1; step();
        // R10: branch waits on special-register move
        clear_stim(); s_v = 1; s_u[0] = 5; s_p[0] = 1; s_pend = 1; step();
        // R10: flag ignored on non-branch unit
        clear_stim(); s_v = 1; s_u[0] = 3; s_p[0] = 1; s_pend = 1; step();
        // R8: port budget
        clear_stim(); s_v = 3; s_u[0] = 0; s_u[1] = 1; s_u[2] = 2;
        s_n[0] = 3; s_n[1] = 2; s_n[2] = 1; s_ports = 5; step();
        // R13: over-release
        clear_stim(); s_cbr = 7; s_renr[3] = 4; step();
        clear_stim(); s_rsr[0] = 1; s_rsr[1] = 1; s_rsr[2] = 1; s_rsr[3] = 1;
        s_rsr[4] = 1; s_rsr[5] = 1; s_cbr = 4; s_renr[1] = 4; s_renr[2] = 4; s_renr[3] = 4; step();

        for (int cyc = 0; cyc < 4000; cyc++) begin
            rand_stim(((cyc / 150) % 2) == 0);
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule